// File: doc/BRIEF.md
# Pin event detector

This block watches a bank of general-purpose input pins and turns selected pin activity into either CPU interrupts or DMA requests. Every pin owns a small register holding a 4-bit mode code and a one-bit event flag. The mode code selects whether the pin is idle, raises a DMA request on chosen edges, or raises an interrupt on chosen edges or on a held level. When the selected condition is seen, the flag latches.

Software configures the pins and clears flags through a simple single-cycle register port. A flag in an interrupt mode stays set until software writes a one to it. A flag in a DMA mode drops when the DMA engine acknowledges the transfer. Each pin input passes through a synchronizer before edge detection. The interrupt output is shared by all pins. DMA request and acknowledge lines are per pin.

Top module: `pin_event_detector`

## Requirements
- R1: Mode code 0000 and every code other than 0001, 0010, 0011, 1000, 1001, 1010, 1011 and 1100 never set the flag, and they raise neither irq_o nor any DMA request.
- R2: Code 0001 sets the flag on a rising pin edge, 0010 on a falling edge and 0011 on either edge. In these DMA modes dma_req_o[n] is high while the flag is set, and irq_o is not driven by that pin.
- R3: Code 1001 sets the flag on a rising edge, 1010 on a falling edge and 1011 on either edge. In these modes the flag drives irq_o.
- R4: Code 1000 sets the flag on every cycle the synchronized pin is 0, and code 1100 on every cycle it is 1.
- R5: Register n (bus_addr = n) holds the mode code of pin n in bits [3:0] and its flag in bit 4. Reads are combinational. A write loads bits [3:0] into the mode code. Bit 4 written as 1 clears the flag, and bit 4 written as 0 leaves the flag unchanged.
- R6: A one-cycle pulse on dma_ack_i[n] clears the flag of pin n when that pin is in a DMA mode. In any other mode the pulse is ignored.
- R7: When a set condition and a clear (software write-one or DMA acknowledge) fall on the same clock edge, the flag stays set. In a level mode with the pin still active, a software clear therefore leaves the flag at 1.
- R8: irq_o is the OR of the flags of all pins in an interrupt mode (codes 1000, 1001, 1010, 1011, 1100). dma_req_o[n] is the flag of pin n while that pin is in a DMA mode, and 0 otherwise.
- R9: A change on pin_i[n] is synchronized through two stages. With an edge mode selected, the flag shows the change after the third rising clock edge that follows it, and does not show it after the second.
- R10: After reset every mode code and every flag read 0, and irq_o and all dma_req_o bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | NUM_PINS | Raw pin levels |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register index, one register per pin |
| bus_wdata | input | 5 | Write data: [4] flag clear, [3:0] mode code |
| bus_rdata | output | 5 | Read data: [4] flag, [3:0] mode code |
| irq_o | output | 1 | Combined interrupt request |
| dma_req_o | output | NUM_PINS | Per-pin DMA request |
| dma_ack_i | input | NUM_PINS | Per-pin DMA transfer-complete pulse |

## Verification
The bench builds the block with NUM_PINS = 4 and SYNC_STAGES = 2. Four pins let the mode table rotate through every register address. They also let the directed tests hold an interrupt flag, a level flag and a DMA flag on separate pins at the same time, so the sharing of irq_o and the routing of acknowledges to one pin can be observed. Two stages fix the three-edge latency that the timing test measures, and they give the exact cycle in which a pin edge and an acknowledge collide.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;

  localparam int CFG_W    = 4;
  localparam int FLAG_POS = CFG_W;

  localparam logic [CFG_W-1:0] MD_OFF      = 4'b0000;
  localparam logic [CFG_W-1:0] MD_DMA_RISE = 4'b0001;
  localparam logic [CFG_W-1:0] MD_DMA_FALL = 4'b0010;
  localparam logic [CFG_W-1:0] MD_DMA_BOTH = 4'b0011;
  localparam logic [CFG_W-1:0] MD_INT_LOW  = 4'b1000;
  localparam logic [CFG_W-1:0] MD_INT_RISE = 4'b1001;
  localparam logic [CFG_W-1:0] MD_INT_FALL = 4'b1010;
  localparam logic [CFG_W-1:0] MD_INT_BOTH = 4'b1011;
  localparam logic [CFG_W-1:0] MD_INT_HIGH = 4'b1100;

  function automatic logic code_dma(input logic [CFG_W-1:0] c);
    return (c == MD_DMA_RISE) || (c == MD_DMA_FALL) || (c == MD_DMA_BOTH);
  endfunction

  function automatic logic code_int(input logic [CFG_W-1:0] c);
    return (c == MD_INT_LOW) || (c == MD_INT_RISE) || (c == MD_INT_FALL) ||
           (c == MD_INT_BOTH) || (c == MD_INT_HIGH);
  endfunction

  // Set condition for one pin given its mode, current and previous level.
  function automatic logic evt_hit(input logic [CFG_W-1:0] c,
                                   input logic cur, input logic prev);
    logic rise, fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    case (c)
      MD_DMA_RISE, MD_INT_RISE: evt_hit = rise;
      MD_DMA_FALL, MD_INT_FALL: evt_hit = fall;
      MD_DMA_BOTH, MD_INT_BOTH: evt_hit = rise | fall;
      MD_INT_LOW:               evt_hit = ~cur;
      MD_INT_HIGH:              evt_hit = cur;
      default:                  evt_hit = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pin_evt_rstsync.sv
module pin_evt_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] st_q, st_d;

  always_comb begin
    st_d = {st_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= 2'b00;
    else        st_q <= st_d;
  end

  assign rst_n_s = st_q[1];
endmodule

// File: rtl/pin_evt_sync.sv
module pin_evt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/pin_evt_cell.sv
module pin_evt_cell
  import pin_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_s,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wd,
  input  logic             clr_wr,
  input  logic             dma_ack,
  output logic [CFG_W-1:0] cfg_q,
  output logic             flag_q,
  output logic             irq_src,
  output logic             dma_req
);
  logic             prev_q, prev_d;
  logic [CFG_W-1:0] cfg_d;
  logic             flag_d;
  logic             set_hit, clr_hit;

  always_comb begin
    set_hit = evt_hit(cfg_q, pin_s, prev_q);
    clr_hit = clr_wr | (dma_ack & code_dma(cfg_q));
    flag_d  = set_hit | (flag_q & ~clr_hit);
    cfg_d   = cfg_we ? cfg_wd : cfg_q;
    prev_d  = pin_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= MD_OFF;
      flag_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      flag_q <= flag_d;
      prev_q <= prev_d;
    end
  end

  assign irq_src = flag_q & code_int(cfg_q);
  assign dma_req = flag_q & code_dma(cfg_q);
endmodule

// File: rtl/pin_event_detector.sv
module pin_event_detector
  import pin_evt_pkg::*;
#(
  parameter  int NUM_PINS    = 8,
  parameter  int SYNC_STAGES = 2,
  localparam int ADDR_W      = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
  localparam int REG_W       = CFG_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [REG_W-1:0]    bus_wdata,
  output logic [REG_W-1:0]    bus_rdata,
  output logic                irq_o,
  output logic [NUM_PINS-1:0] dma_req_o,
  input  logic [NUM_PINS-1:0] dma_ack_i
);
  logic                           rst_n_s;
  logic [NUM_PINS-1:0]            pin_s;
  logic [NUM_PINS-1:0]            sel_wr;
  logic [NUM_PINS-1:0]            flag_all;
  logic [NUM_PINS-1:0]            irq_src;
  logic [NUM_PINS-1:0][CFG_W-1:0] cfg_all;

  pin_evt_rstsync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign sel_wr[i] = bus_wr && (bus_addr == ADDR_W'(i));

    pin_evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n_s),
      .d     (pin_i[i]),
      .q     (pin_s[i])
    );

    pin_evt_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .pin_s   (pin_s[i]),
      .cfg_we  (sel_wr[i]),
      .cfg_wd  (bus_wdata[CFG_W-1:0]),
      .clr_wr  (sel_wr[i] & bus_wdata[FLAG_POS]),
      .dma_ack (dma_ack_i[i]),
      .cfg_q   (cfg_all[i]),
      .flag_q  (flag_all[i]),
      .irq_src (irq_src[i]),
      .dma_req (dma_req_o[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (bus_addr == ADDR_W'(i)) bus_rdata = {flag_all[i], cfg_all[i]};
    end
  end

  assign irq_o = |irq_src;
endmodule

// File: rtl/pin_event_detector_chk.sv
module pin_event_detector_chk
  import pin_evt_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 3,
  parameter int REG_W    = 5
) (
  input logic                           clk,
  input logic                           rst_ok,
  input logic                           bus_wr,
  input logic [ADDR_W-1:0]              bus_addr,
  input logic [REG_W-1:0]               bus_wdata,
  input logic                           irq_o,
  input logic [NUM_PINS-1:0]            dma_req_o,
  input logic [NUM_PINS-1:0]            dma_ack_i,
  input logic [NUM_PINS-1:0]            flag_all,
  input logic [NUM_PINS-1:0][CFG_W-1:0] cfg_all
);

  // R8
  r8_irq_src_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    irq_o |-> (flag_all != '0));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    // R1
    r1_noset_chk: assert property (@(posedge clk) disable iff (!rst_ok)
      $rose(flag_all[i]) |-> (code_dma($past(cfg_all[i])) || code_int($past(cfg_all[i]))));

    // R5
    r5_cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_ok)
      (bus_wr && bus_addr == ADDR_W'(i)) |=> (cfg_all[i] == $past(bus_wdata[CFG_W-1:0])));

    // R5
    r5_zero_keep_chk: assert property (@(posedge clk) disable iff (!rst_ok)
      (bus_wr && bus_addr == ADDR_W'(i) && !bus_wdata[REG_W-1] && flag_all[i]) |=> flag_all[i]);

    // R6
    r6_ack_ignore_chk: assert property (@(posedge clk) disable iff (!rst_ok)
      (dma_ack_i[i] && !code_dma(cfg_all[i]) && flag_all[i] &&
       !(bus_wr && bus_addr == ADDR_W'(i) && bus_wdata[REG_W-1])) |=> flag_all[i]);

    // R8
    r8_dma_req_chk: assert property (@(posedge clk) disable iff (!rst_ok)
      dma_req_o[i] |-> (flag_all[i] && code_dma(cfg_all[i])));
  end
endmodule

bind pin_event_detector pin_event_detector_chk #(
  .NUM_PINS (NUM_PINS),
  .ADDR_W   (ADDR_W),
  .REG_W    (REG_W)
) u_chk (
  .clk       (clk),
  .rst_ok    (rst_n_s),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq_o     (irq_o),
  .dma_req_o (dma_req_o),
  .dma_ack_i (dma_ack_i),
  .flag_all  (flag_all),
  .cfg_all   (cfg_all)
);

// File: tb/pin_event_detector_bench.sv
`timescale 1ns/1ps
module pin_event_detector_bench;
  localparam int NP = 4;
  localparam int AW = $clog2(NP);
  localparam int RW = 5;
  localparam int NV = 23;

  // {mode[3:0], pin_start, pin_end, exp_flag, exp_irq, exp_dma}
  localparam logic [8:0] VEC [NV] = '{
    9'b0000_0_1_0_0_0, 9'b0000_1_0_0_0_0,
    9'b0001_0_1_1_0_1, 9'b0001_1_0_0_0_0,
    9'b0010_1_0_1_0_1, 9'b0010_0_1_0_0_0,
    9'b0011_0_1_1_0_1, 9'b0011_1_0_1_0_1,
    9'b1001_0_1_1_1_0, 9'b1001_1_0_0_0_0,
    9'b1010_1_0_1_1_0, 9'b1010_0_1_0_0_0,
    9'b1011_0_1_1_1_0, 9'b1011_1_0_1_1_0,
    9'b1000_0_0_1_1_0, 9'b1000_1_1_0_0_0,
    9'b1100_1_1_1_1_0, 9'b1100_0_0_0_0_0,
    9'b0100_0_1_0_0_0, 9'b0111_1_0_0_0_0,
    9'b1111_1_1_0_0_0, 9'b1101_0_0_0_0_0,
    9'b0101_0_1_0_0_0
  };

  logic          clk;
  logic          rst_n;
  logic [NP-1:0] pins;
  logic          bus_wr;
  logic [AW-1:0] bus_addr;
  logic [RW-1:0] bus_wdata;
  logic [RW-1:0] bus_rdata;
  logic          irq_o;
  logic [NP-1:0] dma_req_o;
  logic [NP-1:0] dma_ack;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  pin_event_detector #(.NUM_PINS(NP), .SYNC_STAGES(2)) u_pin_event_detector (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_i     (pins),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .dma_req_o (dma_req_o),
    .dma_ack_i (dma_ack)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk_eq(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [3:0] c, input logic clr);
    @(negedge clk);
    bus_wr    = 1'b1;
    bus_addr  = AW'(a);
    bus_wdata = {clr, c};
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input int a, output logic [RW-1:0] v);
    bus_addr = AW'(a);
    #1 v = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pins = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; dma_ack = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  function automatic string mode_tag(input logic [3:0] c);
    if (c == 4'b0001 || c == 4'b0010 || c == 4'b0011) return "R2";
    if (c == 4'b1001 || c == 4'b1010 || c == 4'b1011) return "R3";
    if (c == 4'b1000 || c == 4'b1100) return "R4";
    return "R1";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [RW-1:0] v;
    logic [3:0]    c;
    int            p;
    do_reset();

    // R10 reset state
    for (int k = 0; k < NP; k++) begin
      rd(k, v);
      chk_eq("R10 register after reset", v, 0);
    end
    chk_eq("R10 irq after reset", irq_o, 0);
    chk_eq("R10 dma_req after reset", dma_req_o, 0);

    // table walk over modes and pin patterns
    for (int k = 0; k < NV; k++) begin
      p = k % NP;
      c = VEC[k][8:5];
      pins[p] = VEC[k][4];
      repeat (4) @(negedge clk);
      wr(p, c, 1'b0);
      pins[p] = VEC[k][3];
      repeat (5) @(negedge clk);
      rd(p, v);
      chk_eq({mode_tag(c), " flag"}, v[4], VEC[k][2]);
      chk_eq({mode_tag(c), " R8 irq"}, irq_o, VEC[k][1]);
      chk_eq({mode_tag(c), " R8 dma_req"}, dma_req_o[p], VEC[k][0]);
      wr(p, 4'b0000, 1'b0);
      wr(p, 4'b0000, 1'b1);
    end

    do_reset();

    // R9 synchronizer latency, rising-edge interrupt on pin 0
    wr(0, 4'b1001, 1'b0);
    pins[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    #1 chk_eq("R9 no flag after two edges", irq_o, 0);
    @(negedge clk);
    #1 chk_eq("R9 flag after third edge", irq_o, 1);

    // R5 register layout, zero write keeps flag, one write clears it
    rd(0, v);
    chk_eq("R5 readback flag+mode", v, 5'b1_1001);
    wr(0, 4'b1001, 1'b0);
    rd(0, v);
    chk_eq("R5 zero write keeps flag", v[4], 1);
    wr(0, 4'b1001, 1'b1);
    rd(0, v);
    chk_eq("R5 one write clears flag", v, 5'b0_1001);
    chk_eq("R5 irq after clear", irq_o, 0);

    // R4 / R7 level-high on pin 1: clear while active leaves flag set
    pins[1] = 1'b1;
    repeat (4) @(negedge clk);
    wr(1, 4'b1100, 1'b0);
    repeat (2) @(negedge clk);
    rd(1, v);
    chk_eq("R4 level high sets flag", v[4], 1);
    wr(1, 4'b1100, 1'b1);
    rd(1, v);
    chk_eq("R7 level flag survives clear", v[4], 1);
    pins[1] = 1'b0;
    repeat (4) @(negedge clk);
    wr(1, 4'b1100, 1'b1);
    rd(1, v);
    chk_eq("R7 clear after pin inactive", v[4], 0);

    // R6 DMA acknowledge on pin 2
    wr(2, 4'b0001, 1'b0);
    pins[2] = 1'b1;
    repeat (4) @(negedge clk);
    #1 chk_eq("R2 dma request raised", dma_req_o[2], 1);
    chk_eq("R8 dma mode not on irq", irq_o, 0);
    dma_ack[2] = 1'b1;
    @(negedge clk);
    dma_ack[2] = 1'b0;
    #1 chk_eq("R6 ack drops request", dma_req_o[2], 0);
    rd(2, v);
    chk_eq("R6 ack clears flag", v[4], 0);

    // R6 ack ignored in interrupt mode on pin 3
    wr(3, 4'b1001, 1'b0);
    pins[3] = 1'b1;
    repeat (4) @(negedge clk);
    rd(3, v);
    chk_eq("R3 pin3 flag set", v[4], 1);
    dma_ack[3] = 1'b1;
    @(negedge clk);
    dma_ack[3] = 1'b0;
    rd(3, v);
    chk_eq("R6 ack ignored in interrupt mode", v[4], 1);
    chk_eq("R6 irq still high", irq_o, 1);

    // R7 edge and acknowledge on the same clock edge, pin 2
    pins[2] = 1'b0;
    repeat (4) @(negedge clk);
    #1 chk_eq("R2 falling edge ignored in rise mode", dma_req_o[2], 0);
    pins[2] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    dma_ack[2] = 1'b1;
    @(negedge clk);
    dma_ack[2] = 1'b0;
    #1 chk_eq("R7 set wins over ack", dma_req_o[2], 1);

    // R8 interrupt OR across pins 0 and 3
    wr(0, 4'b1011, 1'b0);
    pins[0] = 1'b0;
    repeat (4) @(negedge clk);
    rd(0, v);
    chk_eq("R3 either-edge falling sets flag", v[4], 1);
    wr(3, 4'b1001, 1'b1);
    #1 chk_eq("R8 irq held by other pin", irq_o, 1);
    wr(0, 4'b1011, 1'b1);
    #1 chk_eq("R8 irq low with only dma flag", irq_o, 0);
    chk_eq("R8 dma flag kept", dma_req_o[2], 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule